// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block is a small, fully associative translation buffer. It maps a 31-bit virtual byte address to a 27-bit physical address. The low 12 bits are the page offset and pass through unchanged. Only the 19-bit page number is translated. Every entry compares its stored virtual page number with the incoming one in the same cycle. The entry that matches supplies its 15-bit physical page number.

Lookup is purely combinational. A miss is flagged so that an external page-table walker can fetch the translation. The walker then installs it through a one-cycle fill port, and the new entry can be looked up from the next cycle on. The fill logic picks a free slot first. When every slot is in use, it overwrites slots in round-robin order. A fill for a page that is already present rewrites that entry in place. A flush input empties the whole buffer in one cycle.

The entry count is a parameter and defaults to 2.

Top module: `xlat_tlb`

## Requirements
- R1: On a hit, `lk_paddr[26:12]` is the physical page number of the matching entry and `lk_paddr[11:0]` equals `lk_vaddr[11:0]`. The virtual page number is `lk_vaddr[30:12]`.
- R2: `lk_hit` is 1 when `lk_valid` is 1 and any valid entry holds the virtual page number `lk_vaddr[30:12]`.
- R3: `lk_miss` is 1 when `lk_valid` is 1 and no valid entry matches. On a miss, `lk_paddr` reads zero.
- R4: After synchronous reset, every entry is invalid, so every lookup misses. The replacement pointer starts at slot 0.
- R5: A fill (`fill_en`=1) for a page that is not present writes the lowest-indexed invalid slot if one exists. The write takes effect at the next rising edge, and no valid entry is disturbed.
- R6: With all slots valid, a fill for a new page overwrites the slot named by the replacement pointer. The pointer then advances by one and wraps from the last slot to slot 0. The pointer moves only on such an overwrite.
- R7: A fill whose page is already held by a valid entry updates that entry's physical page number. It allocates nothing, never leaves two valid entries with the same virtual page number, and does not move the replacement pointer.
- R8: `flush`=1 clears every valid bit at the next edge. A fill in the same cycle is dropped.
- R9: With `lk_valid`=0, `lk_hit` and `lk_miss` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vaddr | input | 31 | Virtual byte address to translate |
| lk_paddr | output | 27 | Translated physical address (zero on a miss) |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | Request present but no translation held |
| fill_en | input | 1 | Install a translation this cycle |
| fill_vpn | input | 19 | Virtual page number to install |
| fill_ppn | input | 15 | Physical page number to install |
| flush | input | 1 | Invalidate all entries |

## Verification
The bench fills the buffer to capacity and then keeps filling new pages. It checks that the evictions alternate between slots. A design that always evicts one slot, or evicts on every fill, would lose the wrong page and turn a later lookup into a miss.

The bench then refills a page that is already present and follows it with one more new page. A design that duplicates the entry, or that advances the pointer on an update, would evict the wrong page.

Further checks cover a flush issued together with a fill, and offsets at both extremes, including the all-ones page. A design that leaked a fill past a flush would hit afterwards. A design that mangled the offset or mis-steered the output selector would return the wrong physical address.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int VA_W  = 31;
    localparam int OFF_W = 12;
    localparam int PPN_W = 15;
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PA_W  = PPN_W + OFF_W;

    typedef logic [VPN_W-1:0] vpn_t;
    typedef logic [PPN_W-1:0] ppn_t;
    typedef logic [OFF_W-1:0] off_t;

    typedef struct packed {
        vpn_t vpn;
        off_t off;
    } vaddr_t;

    typedef struct packed {
        ppn_t ppn;
        off_t off;
    } paddr_t;

    typedef struct packed {
        logic en;
        vpn_t vpn;
        ppn_t ppn;
    } fill_req_t;

    function automatic int unsigned ptr_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/xlat_match.sv
module xlat_match
    import xlat_pkg::*;
#(
    parameter int N = 2
) (
    input  logic [N-1:0]        valid,
    input  logic [N-1:0][VPN_W-1:0] vpn,
    input  vpn_t                key,
    output logic [N-1:0]        match
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = valid[g] && (vpn[g] == key);
    end
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim
    import xlat_pkg::*;
#(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] valid,
    input  logic         alloc,
    output logic [N-1:0] sel
);
    localparam int PW = ptr_width(N);
    localparam logic [PW-1:0] LAST = PW'(N - 1);

    logic [PW-1:0] rr_q;
    logic [N-1:0]  free_sel;
    logic          any_free;

    always_comb begin
        free_sel = '0;
        any_free = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (!valid[i] && !any_free) begin
                free_sel[i] = 1'b1;
                any_free    = 1'b1;
            end
        end
    end

    always_comb begin
        sel = '0;
        if (alloc) begin
            if (any_free) begin
                sel = free_sel;
            end else begin
                for (int i = 0; i < N; i++) begin
                    sel[i] = (rr_q == PW'(i));
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_q <= '0;
        end else if (alloc && !any_free) begin
            rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
        end
    end
endmodule

// File: rtl/xlat_store.sv
module xlat_store
    import xlat_pkg::*;
#(
    parameter int N = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    flush,
    input  logic [N-1:0]            wr_sel,
    input  vpn_t                    wr_vpn,
    input  ppn_t                    wr_ppn,
    output logic [N-1:0]            valid,
    output logic [N-1:0][VPN_W-1:0] vpn,
    output logic [N-1:0][PPN_W-1:0] ppn
);
    for (genvar g = 0; g < N; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                valid[g] <= 1'b0;
                vpn[g]   <= '0;
                ppn[g]   <= '0;
            end else if (flush) begin
                valid[g] <= 1'b0;
            end else if (wr_sel[g]) begin
                valid[g] <= 1'b1;
                vpn[g]   <= wr_vpn;
                ppn[g]   <= wr_ppn;
            end
        end
    end
endmodule

// File: rtl/xlat_pmux.sv
module xlat_pmux
    import xlat_pkg::*;
#(
    parameter int N = 2
) (
    input  logic [N-1:0]            sel,
    input  logic [N-1:0][PPN_W-1:0] ppn,
    output ppn_t                    out
);
    if (N == 2) begin : g_two
        assign out = sel[1] ? ppn[1] : (sel[0] ? ppn[0] : '0);
    end else begin : g_wide
        always_comb begin
            out = '0;
            for (int i = 0; i < N; i++) begin
                out |= ppn[i] & {PPN_W{sel[i]}};
            end
        end
    end
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lk_valid,
    input  logic [VA_W-1:0]  lk_vaddr,
    output logic [PA_W-1:0]  lk_paddr,
    output logic             lk_hit,
    output logic             lk_miss,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             flush
);
    logic [ENTRIES-1:0]            ent_valid;
    logic [ENTRIES-1:0][VPN_W-1:0] ent_vpn;
    logic [ENTRIES-1:0][PPN_W-1:0] ent_ppn;

    vaddr_t    va;
    paddr_t    pa;
    fill_req_t req;
    ppn_t      sel_ppn;

    logic [ENTRIES-1:0] lk_match;
    logic [ENTRIES-1:0] fl_match;
    logic [ENTRIES-1:0] new_sel;
    logic [ENTRIES-1:0] wr_sel;
    logic               any_match;
    logic               fl_dup;
    logic               fl_take;
    logic               fl_new;

    assign va  = vaddr_t'(lk_vaddr);
    assign req = '{en: fill_en, vpn: fill_vpn, ppn: fill_ppn};

    xlat_match #(.N(ENTRIES)) u_lk_cmp (
        .valid (ent_valid),
        .vpn   (ent_vpn),
        .key   (va.vpn),
        .match (lk_match)
    );

    xlat_match #(.N(ENTRIES)) u_fl_cmp (
        .valid (ent_valid),
        .vpn   (ent_vpn),
        .key   (req.vpn),
        .match (fl_match)
    );

    assign fl_take = req.en && !flush;
    assign fl_dup  = |fl_match;
    assign fl_new  = fl_take && !fl_dup;

    xlat_victim #(.N(ENTRIES)) u_victim (
        .clk   (clk),
        .rst   (rst),
        .valid (ent_valid),
        .alloc (fl_new),
        .sel   (new_sel)
    );

    assign wr_sel = fl_take ? (fl_dup ? fl_match : new_sel) : '0;

    xlat_store #(.N(ENTRIES)) u_store (
        .clk    (clk),
        .rst    (rst),
        .flush  (flush),
        .wr_sel (wr_sel),
        .wr_vpn (req.vpn),
        .wr_ppn (req.ppn),
        .valid  (ent_valid),
        .vpn    (ent_vpn),
        .ppn    (ent_ppn)
    );

    xlat_pmux #(.N(ENTRIES)) u_pmux (
        .sel (lk_match),
        .ppn (ent_ppn),
        .out (sel_ppn)
    );

    assign any_match = |lk_match;
    assign lk_hit    = lk_valid && any_match;
    assign lk_miss   = lk_valid && !any_match;

    always_comb begin
        pa = '0;
        if (lk_hit) begin
            pa.ppn = sel_ppn;
            pa.off = va.off;
        end
    end
    assign lk_paddr = pa;
endmodule

// File: rtl/xlat_tlb_chk.sv
module xlat_tlb_chk
    import xlat_pkg::*;
#(
    parameter int N = 2
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    lk_valid,
    input logic [VA_W-1:0]         lk_vaddr,
    input logic [PA_W-1:0]         lk_paddr,
    input logic                    lk_hit,
    input logic                    lk_miss,
    input logic                    fill_en,
    input logic [VPN_W-1:0]        fill_vpn,
    input logic                    flush,
    input logic [N-1:0]            ent_valid,
    input logic [N-1:0][VPN_W-1:0] ent_vpn,
    input logic [N-1:0][PPN_W-1:0] ent_ppn
);
    logic [N-1:0] key_hits;
    logic         key_ppn_ok;
    logic [N-1:0] filled_hits;
    logic         fill_q;
    logic         flush_q;
    vpn_t         fvpn_q;

    always_comb begin
        key_ppn_ok  = 1'b0;
        for (int i = 0; i < N; i++) begin
            key_hits[i]    = ent_valid[i] && (ent_vpn[i] == lk_vaddr[VA_W-1:OFF_W]);
            filled_hits[i] = ent_valid[i] && (ent_vpn[i] == fvpn_q);
            if (key_hits[i] && ent_ppn[i] == lk_paddr[PA_W-1:OFF_W]) key_ppn_ok = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_q  <= 1'b0;
            flush_q <= 1'b0;
            fvpn_q  <= '0;
        end else begin
            fill_q  <= fill_en && !flush;
            flush_q <= flush;
            fvpn_q  <= fill_vpn;
        end
    end

    // R1
    hit_paddr_chk: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> (key_ppn_ok && lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]));

    // R3
    miss_no_entry_chk: assert property (@(posedge clk) disable iff (rst)
        lk_miss |-> (key_hits == '0 && lk_paddr == '0));

    // R5
    fill_lands_chk: assert property (@(posedge clk) disable iff (rst)
        fill_q |-> (filled_hits != '0));

    // R7
    no_dup_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(key_hits) <= 1);

    // R8
    flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
        flush_q |-> (ent_valid == '0));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |-> (!lk_hit && !lk_miss));
endmodule

bind xlat_tlb xlat_tlb_chk #(.N(ENTRIES)) u_xlat_chk (
    .clk       (clk),
    .rst       (rst),
    .lk_valid  (lk_valid),
    .lk_vaddr  (lk_vaddr),
    .lk_paddr  (lk_paddr),
    .lk_hit    (lk_hit),
    .lk_miss   (lk_miss),
    .fill_en   (fill_en),
    .fill_vpn  (fill_vpn),
    .flush     (flush),
    .ent_valid (ent_valid),
    .ent_vpn   (ent_vpn),
    .ent_ppn   (ent_ppn)
);

// File: tb/test_xlat_tlb.sv
module test_xlat_tlb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 1'b0;
    logic [30:0] lk_vaddr = '0;
    logic [26:0] lk_paddr;
    logic        lk_hit;
    logic        lk_miss;
    logic        fill_en = 1'b0;
    logic [18:0] fill_vpn = '0;
    logic [14:0] fill_ppn = '0;
    logic        flush = 1'b0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xlat_tlb #(.ENTRIES(2)) i_xlat_tlb (
        .clk      (clk),
        .rst      (rst),
        .lk_valid (lk_valid),
        .lk_vaddr (lk_vaddr),
        .lk_paddr (lk_paddr),
        .lk_hit   (lk_hit),
        .lk_miss  (lk_miss),
        .fill_en  (fill_en),
        .fill_vpn (fill_vpn),
        .fill_ppn (fill_ppn),
        .flush    (flush)
    );

    task automatic lookup(input logic [30:0] va, input bit exp_hit,
                          input logic [26:0] exp_pa, input string req);
        @(negedge clk);
        lk_valid = 1'b1;
        lk_vaddr = va;
        #1;
        checks++;
        if (lk_hit !== exp_hit || lk_miss !== !exp_hit || lk_paddr !== exp_pa) begin
            failures++;
            $display("FAIL %s va=%h: hit=%b miss=%b pa=%h expected hit=%b miss=%b pa=%h",
                     req, va, lk_hit, lk_miss, lk_paddr, exp_hit, !exp_hit, exp_pa);
        end
        lk_valid = 1'b0;
    endtask

    task automatic do_fill(input logic [18:0] v, input logic [14:0] p, input bit with_flush);
        @(negedge clk);
        fill_en  = 1'b1;
        fill_vpn = v;
        fill_ppn = p;
        flush    = with_flush;
        @(negedge clk);
        fill_en  = 1'b0;
        flush    = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic t_reset();
        // R4: empty after reset
        lookup(31'h0000_247C, 1'b0, '0, "R4");
        lookup(31'h0000_0000, 1'b0, '0, "R4");
    endtask

    task automatic t_first_fill();
        do_fill(19'h00002, 15'h7FFF, 1'b0);
        // R1, R2: translation with offset kept
        lookup(31'h0000_247C, 1'b1, 27'h7FFF47C, "R1");
        do_fill(19'h00005, 15'h1234, 1'b0);
        // R5: second fill takes the free slot, first entry stays
        lookup(31'h0000_247C, 1'b1, 27'h7FFF47C, "R5");
        lookup(31'h0000_5000, 1'b1, 27'h1234000, "R2");
        lookup(31'h0000_5FFF, 1'b1, 27'h1234FFF, "R1");
        // R3: unknown page misses with zero address
        lookup(31'h0000_3000, 1'b0, '0, "R3");
    endtask

    task automatic t_round_robin();
        // R6: full, pointer at slot 0 evicts page 2
        do_fill(19'h00009, 15'h0AAA, 1'b0);
        lookup(31'h0000_2000, 1'b0, '0, "R6");
        lookup(31'h0000_9010, 1'b1, 27'h0AAA010, "R6");
        lookup(31'h0000_5010, 1'b1, 27'h1234010, "R6");
        // R6: pointer now at slot 1 evicts page 5
        do_fill(19'h0000B, 15'h0BBB, 1'b0);
        lookup(31'h0000_5010, 1'b0, '0, "R6");
        lookup(31'h0000_B123, 1'b1, 27'h0BBB123, "R6");
        lookup(31'h0000_9123, 1'b1, 27'h0AAA123, "R6");
    endtask

    task automatic t_update();
        // R7: refill of a present page rewrites it in place
        do_fill(19'h00009, 15'h0555, 1'b0);
        lookup(31'h0000_9ABC, 1'b1, 27'h0555ABC, "R7");
        lookup(31'h0000_BABC, 1'b1, 27'h0BBBABC, "R7");
        // R7: pointer unmoved, so the next new page evicts slot 0 (page 9)
        do_fill(19'h0000C, 15'h0CCC, 1'b0);
        lookup(31'h0000_9ABC, 1'b0, '0, "R7");
        lookup(31'h0000_BABC, 1'b1, 27'h0BBBABC, "R7");
        lookup(31'h0000_C001, 1'b1, 27'h0CCC001, "R7");
    endtask

    task automatic t_flush();
        do_flush();
        // R8: everything gone
        lookup(31'h0000_B000, 1'b0, '0, "R8");
        lookup(31'h0000_C000, 1'b0, '0, "R8");
        // R8: fill together with flush is dropped
        do_fill(19'h0000A, 15'h0111, 1'b1);
        lookup(31'h0000_A000, 1'b0, '0, "R8");
    endtask

    task automatic t_edges();
        do_fill(19'h7FFFF, 15'h7FFF, 1'b0);
        // R1: all-ones page and offset
        lookup(31'h7FFF_FFFF, 1'b1, 27'h7FFFFFF, "R1");
        do_fill(19'h00000, 15'h0001, 1'b0);
        lookup(31'h0000_0000, 1'b1, 27'h0001000, "R1");
    endtask

    task automatic t_idle();
        // R9: no request, no flags
        @(negedge clk);
        lk_valid = 1'b0;
        lk_vaddr = 31'h7FFF_FFFF;
        #1;
        checks++;
        if (lk_hit !== 1'b0 || lk_miss !== 1'b0) begin
            failures++;
            $display("FAIL R9: hit=%b miss=%b expected hit=0 miss=0", lk_hit, lk_miss);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_first_fill();
        t_round_robin();
        t_update();
        t_flush();
        t_edges();
        t_idle();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule